// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block sits between a processor request port and a plain main-memory port. It holds sixteen lines of four 32-bit words. Each memory block has exactly one home line: its block number modulo the line count. Both ports use a valid/ready handshake. A read that finds a valid line with a matching tag completes in the cycle it is presented. Any other read first refills the whole line from memory, then completes.

A static two-bit policy input chooses how writes behave:

- **Write-through (0):** the cached copy and memory are updated together. A write miss is sent to memory without allocating a line.
- **Write-back (1):** only the cache is changed and the line is marked modified. A write miss allocates the line first. A modified line is copied back, all four words, before another block replaces it.
- **Write-invalidate (2):** the write goes to memory only. A line that holds the address loses its valid bit, so the next read refetches it.

Two counters tally completed requests that hit and that missed.

Top module: `wrpolicy_cache`

## Requirements
- R1: After reset every line is invalid, both counters read zero, and cpuReady and memValid are low.
- R2: A read whose line is valid with a matching tag completes in the cycle it is presented, returns the cached word and starts no memory transaction.
- R3: A read miss fetches the four words of the block from memory in ascending offset order (addresses {tag, index, beat, 2'b00}, beat 0 to 3) and then returns the requested word.
- R4: Address bits [3:2] select the word, bits [7:4] select the line and bits [31:8] form the tag; a block with another tag at the same index displaces the resident one, while other indices are untouched.
- R5: With policy 0, a write hit updates the cached word and performs exactly one memory write of the same address and data.
- R6: With policy 0, a write miss performs one memory write and no refill, leaving the resident line of that index in place.
- R7: With policy 1, a write hit changes only the cache with no memory transaction; a write miss refills the line and then writes the word into the cache only.
- R8: With policy 1, a miss on a line holding modified data first writes its four words back to their old addresses, then refills.
- R9: With policy 2, a write performs one memory write and no refill; a resident matching line becomes invalid, so the next read of it misses and returns the written data.
- R10: Each completed request increments exactly one counter: the miss counter if any refill or the lookup found no matching line, otherwise the hit counter.
- R11: While memValid is high and memReady low, memValid, memWrite and memAddr hold steady, and cpuReady stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Write policy: 0 write-through, 1 write-back, 2 write-invalidate |
| cpuValid | input | 1 | Processor request present |
| cpuWrite | input | 1 | Request is a write |
| cpuAddr | input | 32 | Byte address of the request |
| cpuWdata | input | 32 | Write data |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | 32 | Read data, valid with cpuReady |
| memValid | output | 1 | Memory transaction requested |
| memWrite | output | 1 | Memory transaction is a write |
| memAddr | output | 32 | Memory word address (byte form) |
| memWdata | output | 32 | Memory write data |
| memReady | input | 1 | Memory accepts or returns data this cycle |
| memRdata | input | 32 | Memory read data, valid with memReady |
| hitCount | output | 16 | Completed requests that hit |
| missCount | output | 16 | Completed requests that missed |

## Verification
The hardest case to reach is a write-back eviction. It needs a line that was filled, then modified under policy 1, then pushed out by a read of a different tag at the same index. The stimulus builds that history step by step. Earlier write-through traffic leaves the memory copy of the same line holding known values. The bench then checks that all four write-backs arrive, in order, before the first refill read, and that memory ends up holding the modified word.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LINES  = 16;
  localparam int WORDS  = 4;
  localparam int CNT_W  = 16;
  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;

  typedef enum logic [1:0] {
    WR_THROUGH = 2'd0,
    WR_BACK    = 2'd1,
    WR_INVAL   = 2'd2
  } wrMode_e;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_FILL  = 2'd1,
    SRC_EVICT = 2'd2
  } addrSel_e;

  typedef struct packed {
    logic             cpuWr;
    logic             markDirty;
    logic             fillWr;
    logic             lineLoad;
    logic             lineInv;
    logic             cntHit;
    logic             cntMiss;
    addrSel_e         addrSel;
    logic [OFF_W-1:0] beat;
  } dpStrobe_t;
endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES][WORDS];
  logic [LINES-1:0]  validArr;
  logic [LINES-1:0]  dirtyArr;

  logic [TAG_W-1:0] cpuTag;
  logic [IDX_W-1:0] cpuIdx;
  logic [OFF_W-1:0] cpuOff;

  assign cpuTag = cpuAddr[ADDR_W-1 -: TAG_W];
  assign cpuIdx = cpuAddr[BYTE_W+OFF_W +: IDX_W];
  assign cpuOff = cpuAddr[BYTE_W +: OFF_W];

  assign hit         = validArr[cpuIdx] && (tagArr[cpuIdx] == cpuTag);
  assign victimDirty = validArr[cpuIdx] && dirtyArr[cpuIdx];
  assign cpuRdata    = dataArr[cpuIdx][cpuOff];

  always_comb begin
    unique case (st.addrSel)
      SRC_FILL:  memAddr = {cpuTag, cpuIdx, st.beat, {BYTE_W{1'b0}}};
      SRC_EVICT: memAddr = {tagArr[cpuIdx], cpuIdx, st.beat, {BYTE_W{1'b0}}};
      default:   memAddr = cpuAddr;
    endcase
    memWdata = (st.addrSel == SRC_EVICT) ? dataArr[cpuIdx][st.beat] : cpuWdata;
  end

  always_ff @(posedge clk) begin
    if (st.cpuWr)
      dataArr[cpuIdx][cpuOff] <= cpuWdata;
    else if (st.fillWr)
      dataArr[cpuIdx][st.beat] <= memRdata;
    if (st.lineLoad)
      tagArr[cpuIdx] <= cpuTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
    end else begin
      if (st.lineLoad) begin
        validArr[cpuIdx] <= 1'b1;
        dirtyArr[cpuIdx] <= 1'b0;
      end
      if (st.lineInv)   validArr[cpuIdx] <= 1'b0;
      if (st.markDirty) dirtyArr[cpuIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (st.cntHit)  hitCount  <= hitCount + 1'b1;
      if (st.cntMiss) missCount <= missCount + 1'b1;
    end
  end

  AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    st.lineLoad |=> validArr[$past(cpuIdx)] && !dirtyArr[$past(cpuIdx)]); // R8
  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    st.lineInv |=> !validArr[$past(cpuIdx)]); // R9
  AST_HIT_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    st.cntHit |=> (hitCount == $past(hitCount) + 1'b1) && $stable(missCount)); // R10
  AST_MISS_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    st.cntMiss |=> (missCount == $past(missCount) + 1'b1) && $stable(hitCount)); // R10
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       cpuValid,
  input  logic       cpuWrite,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       memReady,
  output logic       cpuReady,
  output logic       memValid,
  output logic       memWrite,
  output dpStrobe_t  st
);
  typedef enum logic [1:0] {S_LOOK, S_EVICT, S_FILL, S_WRITE} state_e;

  state_e           state, nextState;
  logic [OFF_W-1:0] beat, nextBeat;
  logic             missPend;
  wrMode_e          policy;
  logic             lastBeat;

  assign policy   = wrMode_e'(mode);
  assign lastBeat = (beat == OFF_W'(WORDS - 1));

  always_comb begin
    nextState = state;
    nextBeat  = beat;
    cpuReady  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    st        = '0;
    st.addrSel = SRC_CPU;
    st.beat    = beat;
    unique case (state)
      S_LOOK: begin
        if (cpuValid) begin
          if (!cpuWrite || policy == WR_BACK) begin
            if (hit) begin
              cpuReady     = 1'b1;
              st.cpuWr     = cpuWrite;
              st.markDirty = cpuWrite;
              st.cntHit    = !missPend;
              st.cntMiss   = missPend;
            end else begin
              nextState = victimDirty ? S_EVICT : S_FILL;
              nextBeat  = '0;
            end
          end else begin
            st.lineInv = (policy == WR_INVAL) && hit;
            st.cpuWr   = (policy != WR_INVAL) && hit;
            nextState  = S_WRITE;
          end
        end
      end
      S_EVICT: begin
        memValid   = 1'b1;
        memWrite   = 1'b1;
        st.addrSel = SRC_EVICT;
        if (memReady) begin
          nextBeat = beat + 1'b1;
          if (lastBeat) nextState = S_FILL;
        end
      end
      S_FILL: begin
        memValid   = 1'b1;
        st.addrSel = SRC_FILL;
        if (memReady) begin
          st.fillWr = 1'b1;
          nextBeat  = beat + 1'b1;
          if (lastBeat) begin
            st.lineLoad = 1'b1;
            nextState   = S_LOOK;
          end
        end
      end
      default: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        if (memReady) begin
          cpuReady   = 1'b1;
          st.cntHit  = !missPend;
          st.cntMiss = missPend;
          nextState  = S_LOOK;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_LOOK;
      beat     <= '0;
      missPend <= 1'b0;
    end else begin
      state <= nextState;
      beat  <= nextBeat;
      if (cpuReady)
        missPend <= 1'b0;
      else if (state == S_LOOK && nextState != S_LOOK)
        missPend <= !hit;
    end
  end

  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuValid); // R11
  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> memValid && $stable(memWrite)); // R11
  AST_NO_STALL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |-> !cpuReady); // R11
endmodule

// File: rtl/wrpolicy_cache.sv
module wrpolicy_cache
  import cache_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  dpStrobe_t st;
  logic      hit;
  logic      victimDirty;

  cache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .hit(hit), .victimDirty(victimDirty), .memReady(memReady),
    .cpuReady(cpuReady), .memValid(memValid), .memWrite(memWrite), .st(st)
  );

  cache_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .memRdata(memRdata),
    .hit(hit), .victimDirty(victimDirty), .cpuRdata(cpuRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .hitCount(hitCount), .missCount(missCount)
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> $stable(memAddr)); // R11
  AST_READ_DONE_IDLE_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuReady && !cpuWrite) |-> !memValid); // R2
endmodule

// File: tb/sim_wrpolicy_cache.sv
`timescale 1ns/1ps
module sim_wrpolicy_cache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic        cpuReady;
  logic [31:0] cpuRdata;
  logic        memValid, memWrite;
  logic [31:0] memAddr, memWdata;
  logic        memReady;
  logic [31:0] memRdata;
  logic [15:0] hitCount, missCount;

  always #2.5 clk = ~clk;

  wrpolicy_cache u0 (
    .clk(clk), .rstN(rstN), .mode(mode),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata),
    .hitCount(hitCount), .missCount(missCount)
  );

  // memory model
  logic [31:0] memArr [1024];
  logic [32:0] opLog [256];
  int nRd = 0, nWr = 0, nOps = 0, latCnt = 0, memLat = 1;

  function automatic logic [31:0] initVal(input logic [31:0] a);
    return 32'hA000_0000 | a;
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) memArr[i] = initVal(32'(i * 4));
  end

  always @(posedge clk) begin
    if (!rstN) begin
      memReady <= 1'b0;
      memRdata <= '0;
      latCnt   <= 0;
    end else if (memReady) begin
      memReady <= 1'b0;
      latCnt   <= 0;
      opLog[nOps % 256] <= {memWrite, memAddr};
      nOps <= nOps + 1;
      if (memWrite) begin
        memArr[memAddr[11:2]] <= memWdata;
        nWr <= nWr + 1;
      end else begin
        nRd <= nRd + 1;
      end
    end else if (memValid) begin
      if (latCnt >= memLat) begin
        memReady <= 1'b1;
        memRdata <= memArr[memAddr[11:2]];
      end else begin
        latCnt <= latCnt + 1;
      end
    end
  end

  // handshake monitor, sampled away from the active edge
  int hsErr = 0;
  logic pV = 1'b0, pR = 1'b0, pW = 1'b0;
  logic [31:0] pA = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (pV && !pR && (!memValid || memAddr != pA || memWrite != pW)) hsErr <= hsErr + 1;
      if (memValid && !memReady && cpuReady) hsErr <= hsErr + 1;
    end
    pV <= memValid; pR <= memReady; pA <= memAddr; pW <= memWrite;
  end

  int nChk = 0, nFail = 0;
  int expHit = 0, expMiss = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpuReq(input bit w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = w; cpuAddr = a; cpuWdata = d;
    waits = 0;
    forever begin
      #1;
      if (cpuReady) break;
      @(negedge clk);
      waits++;
    end
    rd = cpuRdata;
    @(negedge clk);
    cpuValid = 1'b0; cpuWrite = 1'b0;
  endtask

  task automatic chkCounters(input string req);
    chk(hitCount == 16'(expHit), req, 32'(hitCount), 32'(expHit));
    chk(missCount == 16'(expMiss), req, 32'(missCount), 32'(expMiss));
  endtask

  task automatic testReset();
    chk(hitCount == 0 && missCount == 0, "R1 counters", {hitCount, missCount}, 0);
    chk(!memValid && !cpuReady, "R1 handshake idle", {30'd0, memValid, cpuReady}, 0);
  endtask

  task automatic testReadMiss();
    logic [31:0] rd; int w; int r0 = nRd; int o0 = nOps;
    mode = 2'd0; memLat = 1;
    cpuReq(0, 32'h104, 0, rd, w); expMiss++;
    chk(rd == initVal(32'h104), "R3 miss data", rd, initVal(32'h104));
    chk(nRd - r0 == 4, "R3 refill beats", 32'(nRd - r0), 4);
    for (int k = 0; k < 4; k++)
      chk(opLog[(o0 + k) % 256] == {1'b0, 32'h100 + 32'(k * 4)}, "R3 beat order",
          opLog[(o0 + k) % 256][31:0], 32'h100 + 32'(k * 4));
    chkCounters("R10 after first miss (R1 lines invalid)");
  endtask

  task automatic testReadHit();
    logic [31:0] rd; int w; int o0 = nOps;
    cpuReq(0, 32'h10C, 0, rd, w); expHit++;
    chk(rd == initVal(32'h10C), "R2 hit data", rd, initVal(32'h10C));
    chk(w == 0, "R2 zero wait", 32'(w), 0);
    chk(nOps == o0, "R2 no mem traffic", 32'(nOps - o0), 0);
    chkCounters("R10 hit");
  endtask

  task automatic testWtHit();
    logic [31:0] rd; int w; int wr0 = nWr; int r0 = nRd;
    memLat = 3;
    cpuReq(1, 32'h108, 32'h1111_0108, rd, w); expHit++;
    chk(nWr - wr0 == 1 && nRd == r0, "R5 one mem write", 32'(nWr - wr0), 1);
    chk(memArr[32'h108 >> 2] == 32'h1111_0108, "R5 mem data", memArr[32'h108 >> 2], 32'h1111_0108);
    cpuReq(0, 32'h108, 0, rd, w); expHit++;
    chk(rd == 32'h1111_0108 && w == 0, "R5 cache updated", rd, 32'h1111_0108);
    chkCounters("R10 write-through hit");
  endtask

  task automatic testWtMiss();
    logic [31:0] rd; int w; int wr0 = nWr; int r0 = nRd;
    cpuReq(1, 32'h200, 32'h2222_0200, rd, w); expMiss++;
    chk(nWr - wr0 == 1 && nRd == r0, "R6 write only", 32'(nRd - r0), 0);
    chk(memArr[32'h200 >> 2] == 32'h2222_0200, "R6 mem data", memArr[32'h200 >> 2], 32'h2222_0200);
    cpuReq(0, 32'h104, 0, rd, w); expHit++;
    chk(w == 0 && rd == initVal(32'h104), "R6 resident line kept", rd, initVal(32'h104));
    chkCounters("R10 write-through miss");
  endtask

  task automatic testMapping();
    logic [31:0] rd; int w; int r0;
    memLat = 0;
    cpuReq(0, 32'h204, 0, rd, w); expMiss++;
    chk(rd == initVal(32'h204), "R4 other tag fill", rd, initVal(32'h204));
    r0 = nRd;
    cpuReq(0, 32'h108, 0, rd, w); expMiss++;
    chk(nRd - r0 == 4 && rd == 32'h1111_0108, "R4 displaced refetch", rd, 32'h1111_0108);
    cpuReq(0, 32'h210, 0, rd, w); expMiss++;
    cpuReq(0, 32'h100, 0, rd, w); expHit++;
    chk(w == 0 && rd == initVal(32'h100), "R4 other index untouched", rd, initVal(32'h100));
    chkCounters("R10 mapping");
  endtask

  task automatic testWbHit();
    logic [31:0] rd; int w; int o0 = nOps;
    mode = 2'd1; memLat = 2;
    cpuReq(1, 32'h104, 32'h3333_0104, rd, w); expHit++;
    chk(nOps == o0, "R7 hit no mem traffic", 32'(nOps - o0), 0);
    chk(memArr[32'h104 >> 2] == initVal(32'h104), "R7 mem untouched", memArr[32'h104 >> 2], initVal(32'h104));
    cpuReq(0, 32'h104, 0, rd, w); expHit++;
    chk(rd == 32'h3333_0104, "R7 cache holds new data", rd, 32'h3333_0104);
    chkCounters("R10 write-back hit");
  endtask

  task automatic testEvict();
    logic [31:0] rd; int w; int o0 = nOps;
    cpuReq(0, 32'h304, 0, rd, w); expMiss++;
    chk(nOps - o0 == 8, "R8 evict plus fill", 32'(nOps - o0), 8);
    for (int k = 0; k < 4; k++)
      chk(opLog[(o0 + k) % 256] == {1'b1, 32'h100 + 32'(k * 4)}, "R8 write-back first",
          opLog[(o0 + k) % 256][31:0], 32'h100 + 32'(k * 4));
    chk(opLog[(o0 + 4) % 256] == {1'b0, 32'h300}, "R8 refill after", opLog[(o0 + 4) % 256][31:0], 32'h300);
    chk(memArr[32'h104 >> 2] == 32'h3333_0104, "R8 dirty word saved", memArr[32'h104 >> 2], 32'h3333_0104);
    chk(rd == initVal(32'h304), "R8 new data", rd, initVal(32'h304));
    chkCounters("R10 eviction");
  endtask

  task automatic testWbMiss();
    logic [31:0] rd; int w; int r0 = nRd; int wr0 = nWr;
    cpuReq(1, 32'h420, 32'h4444_0420, rd, w); expMiss++;
    chk(nRd - r0 == 4 && nWr == wr0, "R7 allocate no write", 32'(nWr - wr0), 0);
    chk(memArr[32'h420 >> 2] == initVal(32'h420), "R7 miss mem untouched", memArr[32'h420 >> 2], initVal(32'h420));
    cpuReq(0, 32'h420, 0, rd, w); expHit++;
    chk(w == 0 && rd == 32'h4444_0420, "R7 allocated data", rd, 32'h4444_0420);
    chkCounters("R10 write-back miss");
  endtask

  task automatic testInval();
    logic [31:0] rd; int w; int r0; int wr0;
    mode = 2'd2; memLat = 1;
    cpuReq(0, 32'h530, 0, rd, w); expMiss++;
    r0 = nRd; wr0 = nWr;
    cpuReq(1, 32'h534, 32'h5555_0534, rd, w); expHit++;
    chk(nWr - wr0 == 1 && nRd == r0, "R9 memory only", 32'(nWr - wr0), 1);
    chk(memArr[32'h534 >> 2] == 32'h5555_0534, "R9 mem data", memArr[32'h534 >> 2], 32'h5555_0534);
    r0 = nRd;
    cpuReq(0, 32'h534, 0, rd, w); expMiss++;
    chk(nRd - r0 == 4, "R9 forced refetch", 32'(nRd - r0), 4);
    chk(rd == 32'h5555_0534, "R9 fresh data", rd, 32'h5555_0534);
    chkCounters("R10 write-invalidate");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadMiss();
    testReadHit();
    testWtHit();
    testWtMiss();
    testMapping();
    testWbHit();
    testEvict();
    testWbMiss();
    testInval();
    chk(hsErr == 0, "R11 handshake hold", 32'(hsErr), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChk++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule